// File: doc/BRIEF.md
# Reconfigurable Functional Unit Array

This block is a row-structured matrix of simple 32-bit integer functional units that executes one custom instruction: a small acyclic dataflow graph lifted from a frequently executed basic block. There are five rows of four units each. Every unit has two operand multiplexers and an operation selector. Software loads up to four independent contexts through a word-wide configuration port. Each context sets the operation and operand sources of every unit, the operand-bus entry taps, the choice of results, the graph depth and the resume-address rule.

On `start`, the array captures the eight operand words, the current program counter and a context index. It then waits one clock per configured row of depth while the combinational fabric settles. After that it latches up to six results and the program counter to resume from, and pulses `done`. The controller has three states. ST_IDLE moves to ST_EVAL on an accepted start. ST_EVAL counts down the row depth and moves to ST_DONE when the count reaches one, which is the capture edge. ST_DONE lasts one cycle and returns to ST_IDLE.

Top module: `rfu_array`

## Requirements
- R1: After reset `busy`, `done`, every result word and `next_pc` are zero.
- R2: Unit operation codes (config word bits [3:0]): 0 pass A, 1 A+B, 2 A-B, 3 AND, 4 OR, 5 XOR, 6 NOR, 7 shift left, 8 logical shift right, 9 arithmetic shift right, 10 signed less-than, 11 unsigned less-than, 12 equal; other codes give 0.
- R3: Shifts use only B[4:0] as the amount. The three compares return exactly 1 or 0.
- R4: Operand select codes (A in bits [7:4], B in [11:8]): 0-3 take the previous row's unit of that column (zero in row 1); 4+k takes entry tap k of the unit's own row. Rows 1..5 own 7, 2, 2, 2 and 1 taps, numbered consecutively from tap 0 in row order. A tap index past its row's count gives zero. Tap j picks operand word `tapword[2:0]` from config address 20+j.
- R5: Code 11 in rows 3, 4 and 5 takes the output of row 1 column 3. Code 13 in row 4 takes row 2 column 3. Both codes give zero in any other row.
- R6: Code 12 takes the left neighbour (column-1) in row 3 and the right neighbour (column+1) in row 4. It gives zero at the row ends and in all other rows. This lets a graph run right along row 3 and back along row 4.
- R7: Unit words sit at config address (row-1)*4+column. Address 40 holds depth [2:0], branch enable [3], branch unit [8:4] and skip count [23:16]. Address 41 holds the branch target. With depth d, `done` rises exactly d cycles after the start edge. A depth of 0 counts as 1 and a depth above 5 counts as 5. `busy` is high while the array is evaluating, and `done` lasts one cycle.
- R8: A start request while busy is ignored and does not alter the run in flight.
- R9: Four contexts are selected by `cfg_ctx` on writes and by `start_ctx` on start. A write to one context leaves the others unchanged.
- R10: `next_pc` equals the branch target when branch is enabled and the selected unit's output is nonzero. Otherwise it equals the start pc plus 4 times the skip count.
- R11: Result k is taken from the unit indexed by config address 34+k, bits [4:0]. An index of 20 or more gives zero.
- R12: Results and `next_pc` hold their values from one completion until the next, even when the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | 2 | Context written |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration word |
| start | input | 1 | Begin a custom instruction |
| start_ctx | input | 2 | Context to execute |
| pc_in | input | 32 | Program counter at start |
| operands | input | 256 | Eight operand words, word i at bits [32i+31:32i] |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| results | output | 192 | Six result words, word k at bits [32k+31:32k] |
| next_pc | output | 32 | Resume address |

## Verification
A wrong row counter or state shows up at once as a `done` pulse one or more cycles early or late. The bench measures this against the configured depth, clamps included. A wrong operand route or wrong link topology surfaces at the next completion as a wrong result word, because each test graph gives every unit a distinct value. A stale context or a run restarted while busy shows as results from the wrong context, or as a second `done`, within a few cycles of the first.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
    localparam int ROWS    = 5;
    localparam int COLS    = 4;
    localparam int NUNITS  = ROWS * COLS;
    localparam int NTAPS   = 14;
    localparam int OP_W    = 4;
    localparam int SEL_W   = 4;
    localparam int NSRC    = 1 << SEL_W;
    localparam int DEPTH_W = 3;
    localparam int UNIT_IW = $clog2(NUNITS);

    localparam logic [OP_W-1:0] OP_PASS = 4'd0;
    localparam logic [OP_W-1:0] OP_ADD  = 4'd1;
    localparam logic [OP_W-1:0] OP_SUB  = 4'd2;
    localparam logic [OP_W-1:0] OP_AND  = 4'd3;
    localparam logic [OP_W-1:0] OP_OR   = 4'd4;
    localparam logic [OP_W-1:0] OP_XOR  = 4'd5;
    localparam logic [OP_W-1:0] OP_NOR  = 4'd6;
    localparam logic [OP_W-1:0] OP_SLL  = 4'd7;
    localparam logic [OP_W-1:0] OP_SRL  = 4'd8;
    localparam logic [OP_W-1:0] OP_SRA  = 4'd9;
    localparam logic [OP_W-1:0] OP_SLT  = 4'd10;
    localparam logic [OP_W-1:0] OP_SLTU = 4'd11;
    localparam logic [OP_W-1:0] OP_EQ   = 4'd12;

    localparam int SRC_TAP0   = 4;
    localparam int SRC_LINK_A = 11;
    localparam int SRC_HORIZ  = 12;
    localparam int SRC_LINK_B = 13;
    localparam int MAX_TAPS   = 7;

    typedef struct packed {
        logic [SEL_W-1:0] sel_b;
        logic [SEL_W-1:0] sel_a;
        logic [OP_W-1:0]  op;
    } unit_cfg_t;

    function automatic int row_taps(input int r);
        case (r)
            0:       return 7;
            4:       return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int row_tap_base(input int r);
        int s;
        s = 0;
        for (int i = 0; i < r; i++) s += row_taps(i);
        return s;
    endfunction
endpackage

// File: rtl/rfu_fu.sv
module rfu_fu
    import rfu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic [DW-1:0]   y_o
);
    localparam int SH_W = $clog2(DW);

    logic [SH_W-1:0] shamt;
    assign shamt = b_i[SH_W-1:0];

    always_comb begin
        case (op_i)
            OP_PASS: y_o = a_i;
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_NOR:  y_o = ~(a_i | b_i);
            OP_SLL:  y_o = a_i << shamt;
            OP_SRL:  y_o = a_i >> shamt;
            OP_SRA:  y_o = DW'($signed(a_i) >>> shamt);
            OP_SLT:  y_o = {{(DW-1){1'b0}}, $signed(a_i) < $signed(b_i)};
            OP_SLTU: y_o = {{(DW-1){1'b0}}, a_i < b_i};
            OP_EQ:   y_o = {{(DW-1){1'b0}}, a_i == b_i};
            default: y_o = '0;
        endcase
    end

    always_comb begin
        if (op_i == OP_SLT || op_i == OP_SLTU || op_i == OP_EQ)
            AST_CMP_BOOL: assert (y_o[DW-1:1] == '0); // R3
    end
endmodule

// File: rtl/rfu_cfg_store.sv
module rfu_cfg_store
    import rfu_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NCTX   = 4,
    parameter int N_IN   = 8,
    parameter int N_OUT  = 6,
    parameter int ADDR_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_i,
    input  logic [$clog2(NCTX)-1:0]           wctx_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [DW-1:0]                     wdata_i,
    input  logic [$clog2(NCTX)-1:0]           rctx_i,
    input  logic [$clog2(NCTX)-1:0]           pctx_i,
    output unit_cfg_t [NUNITS-1:0]            ucfg_o,
    output logic [NTAPS-1:0][$clog2(N_IN)-1:0] tap_o,
    output logic [N_OUT-1:0][UNIT_IW-1:0]     osel_o,
    output logic                              bren_o,
    output logic [UNIT_IW-1:0]                brunit_o,
    output logic [7:0]                        skip_o,
    output logic [DW-1:0]                     target_o,
    output logic [DEPTH_W-1:0]                pdepth_o
);
    localparam int OPI_W     = $clog2(N_IN);
    localparam int TAP_IW    = $clog2(NTAPS);
    localparam int OSEL_IW   = $clog2(N_OUT);
    localparam int TAP_BASE  = NUNITS;
    localparam int OSEL_BASE = TAP_BASE + NTAPS;
    localparam int CTRL_ADDR = OSEL_BASE + N_OUT;
    localparam int TGT_ADDR  = CTRL_ADDR + 1;

    unit_cfg_t             unit_m  [NCTX][NUNITS];
    logic [OPI_W-1:0]      tap_m   [NCTX][NTAPS];
    logic [UNIT_IW-1:0]    osel_m  [NCTX][N_OUT];
    logic [DEPTH_W-1:0]    depth_m [NCTX];
    logic                  bren_m  [NCTX];
    logic [UNIT_IW-1:0]    brunit_m[NCTX];
    logic [7:0]            skip_m  [NCTX];
    logic [DW-1:0]         tgt_m   [NCTX];

    logic [ADDR_W-1:0] off_tap, off_osel;
    assign off_tap  = addr_i - ADDR_W'(TAP_BASE);
    assign off_osel = addr_i - ADDR_W'(OSEL_BASE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int x = 0; x < NCTX; x++) begin
                for (int u = 0; u < NUNITS; u++) unit_m[x][u] <= '0;
                for (int t = 0; t < NTAPS; t++)  tap_m[x][t]  <= '0;
                for (int k = 0; k < N_OUT; k++)  osel_m[x][k] <= '0;
                depth_m[x]  <= '0;
                bren_m[x]   <= 1'b0;
                brunit_m[x] <= '0;
                skip_m[x]   <= '0;
                tgt_m[x]    <= '0;
            end
        end else if (we_i) begin
            if (int'(addr_i) < TAP_BASE) begin
                unit_m[wctx_i][addr_i[UNIT_IW-1:0]] <= wdata_i[$bits(unit_cfg_t)-1:0];
            end else if (int'(addr_i) < OSEL_BASE) begin
                tap_m[wctx_i][off_tap[TAP_IW-1:0]] <= wdata_i[OPI_W-1:0];
            end else if (int'(addr_i) < CTRL_ADDR) begin
                osel_m[wctx_i][off_osel[OSEL_IW-1:0]] <= wdata_i[UNIT_IW-1:0];
            end else if (int'(addr_i) == CTRL_ADDR) begin
                depth_m[wctx_i]  <= wdata_i[DEPTH_W-1:0];
                bren_m[wctx_i]   <= wdata_i[3];
                brunit_m[wctx_i] <= wdata_i[4 +: UNIT_IW];
                skip_m[wctx_i]   <= wdata_i[23:16];
            end else if (int'(addr_i) == TGT_ADDR) begin
                tgt_m[wctx_i] <= wdata_i;
            end
        end
    end

    always_comb begin
        for (int u = 0; u < NUNITS; u++) ucfg_o[u] = unit_m[rctx_i][u];
        for (int t = 0; t < NTAPS; t++)  tap_o[t]  = tap_m[rctx_i][t];
        for (int k = 0; k < N_OUT; k++)  osel_o[k] = osel_m[rctx_i][k];
        bren_o   = bren_m[rctx_i];
        brunit_o = brunit_m[rctx_i];
        skip_o   = skip_m[rctx_i];
        target_o = tgt_m[rctx_i];
        pdepth_o = depth_m[pctx_i];
    end
endmodule

// File: rtl/rfu_fabric.sv
module rfu_fabric
    import rfu_pkg::*;
#(
    parameter int DW   = 32,
    parameter int N_IN = 8
) (
    input  logic [N_IN*DW-1:0]                 opnd_i,
    input  unit_cfg_t [NUNITS-1:0]             ucfg_i,
    input  logic [NTAPS-1:0][$clog2(N_IN)-1:0] tap_i,
    output logic [NUNITS-1:0][DW-1:0]          y_o
);
    logic [DW-1:0] tapv [NTAPS];
    logic [DW-1:0] y    [ROWS][COLS];
    logic [DW-1:0] link_a, link_b;

    assign link_a = y[0][COLS-1];
    assign link_b = y[1][COLS-1];

    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        assign tapv[t] = opnd_i[tap_i[t]*DW +: DW];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic [DW-1:0] src [NSRC];

            for (genvar p = 0; p < COLS; p++) begin : g_prev
                if (r > 0) begin : g_y
                    assign src[p] = y[r-1][p];
                end else begin : g_n
                    assign src[p] = '0;
                end
            end

            for (genvar k = 0; k < MAX_TAPS; k++) begin : g_tsel
                if (k < row_taps(r)) begin : g_y
                    assign src[SRC_TAP0+k] = tapv[row_tap_base(r)+k];
                end else begin : g_n
                    assign src[SRC_TAP0+k] = '0;
                end
            end

            if (r >= 2) begin : g_la
                assign src[SRC_LINK_A] = link_a;
            end else begin : g_nla
                assign src[SRC_LINK_A] = '0;
            end

            if (r == 2 && c > 0) begin : g_hl
                assign src[SRC_HORIZ] = y[r][c-1];
            end else if (r == 3 && c < COLS-1) begin : g_hr
                assign src[SRC_HORIZ] = y[r][c+1];
            end else begin : g_nh
                assign src[SRC_HORIZ] = '0;
            end

            if (r == 3) begin : g_lb
                assign src[SRC_LINK_B] = link_b;
            end else begin : g_nlb
                assign src[SRC_LINK_B] = '0;
            end

            for (genvar z = SRC_LINK_B + 1; z < NSRC; z++) begin : g_zero
                assign src[z] = '0;
            end

            logic [DW-1:0] fu_y;
            rfu_fu #(.DW(DW)) u_fu (
                .op_i (ucfg_i[r*COLS+c].op),
                .a_i  (src[ucfg_i[r*COLS+c].sel_a]),
                .b_i  (src[ucfg_i[r*COLS+c].sel_b]),
                .y_o  (fu_y)
            );
            assign y[r][c]        = fu_y;
            assign y_o[r*COLS+c]  = fu_y;
        end
    end
endmodule

// File: rtl/rfu_seq.sv
module rfu_seq
    import rfu_pkg::*;
#(
    parameter int CNT_W = $clog2(ROWS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [DEPTH_W-1:0] depth_i,
    output logic               accept_o,
    output logic               fin_o,
    output logic               busy_o,
    output logic               done_o
);
    typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_DONE} seq_state_e;

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, depth_eff;

    always_comb begin
        if (depth_i == '0)                depth_eff = CNT_W'(1);
        else if (int'(depth_i) > ROWS)    depth_eff = CNT_W'(ROWS);
        else                              depth_eff = CNT_W'(depth_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: if (start_i) begin
                st_d  = ST_EVAL;
                cnt_d = depth_eff;
            end
            ST_EVAL: if (cnt_q == CNT_W'(1)) begin
                st_d  = ST_DONE;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q - CNT_W'(1);
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o = (st_q == ST_IDLE) && start_i;
        fin_o    = (st_q == ST_EVAL) && (cnt_q == CNT_W'(1));
        busy_o   = (st_q == ST_EVAL);
        done_o   = (st_q == ST_DONE);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q >= CNT_W'(1) && int'(cnt_q) <= ROWS)); // R7
    AST_FIN_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> done_o); // R7
endmodule

// File: rtl/rfu_array.sv
module rfu_array
    import rfu_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NCTX   = 4,
    parameter int N_IN   = 8,
    parameter int N_OUT  = 6,
    parameter int ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [$clog2(NCTX)-1:0]   cfg_ctx,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [DW-1:0]             cfg_wdata,
    input  logic                      start,
    input  logic [$clog2(NCTX)-1:0]   start_ctx,
    input  logic [DW-1:0]             pc_in,
    input  logic [N_IN*DW-1:0]        operands,
    output logic                      busy,
    output logic                      done,
    output logic [N_OUT*DW-1:0]       results,
    output logic [DW-1:0]             next_pc
);
    localparam int CTX_W = $clog2(NCTX);
    localparam int OPI_W = $clog2(N_IN);

    logic [CTX_W-1:0]          ctx_q;
    logic [N_IN*DW-1:0]        opnd_q;
    logic [DW-1:0]             pc_q;
    unit_cfg_t [NUNITS-1:0]    ucfg;
    logic [NTAPS-1:0][OPI_W-1:0] tap_cfg;
    logic [N_OUT-1:0][UNIT_IW-1:0] osel;
    logic                      bren;
    logic [UNIT_IW-1:0]        brunit;
    logic [7:0]                skip;
    logic [DW-1:0]             target;
    logic [DEPTH_W-1:0]        pdepth;
    logic [NUNITS-1:0][DW-1:0] fab_y;
    logic                      accept, fin;
    logic [N_OUT*DW-1:0]       res_d;
    logic [DW-1:0]             npc_d;
    logic                      br_taken;

    rfu_cfg_store #(.DW(DW), .NCTX(NCTX), .N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .wctx_i   (cfg_ctx),
        .addr_i   (cfg_addr),
        .wdata_i  (cfg_wdata),
        .rctx_i   (ctx_q),
        .pctx_i   (start_ctx),
        .ucfg_o   (ucfg),
        .tap_o    (tap_cfg),
        .osel_o   (osel),
        .bren_o   (bren),
        .brunit_o (brunit),
        .skip_o   (skip),
        .target_o (target),
        .pdepth_o (pdepth)
    );

    rfu_fabric #(.DW(DW), .N_IN(N_IN)) u_fab (
        .opnd_i (opnd_q),
        .ucfg_i (ucfg),
        .tap_i  (tap_cfg),
        .y_o    (fab_y)
    );

    rfu_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .depth_i  (pdepth),
        .accept_o (accept),
        .fin_o    (fin),
        .busy_o   (busy),
        .done_o   (done)
    );

    always_comb begin
        for (int k = 0; k < N_OUT; k++) begin
            if (int'(osel[k]) < NUNITS) res_d[k*DW +: DW] = fab_y[osel[k]];
            else                        res_d[k*DW +: DW] = '0;
        end
        br_taken = bren && (int'(brunit) < NUNITS) && (fab_y[brunit] != '0);
        npc_d    = br_taken ? target : pc_q + {{(DW-10){1'b0}}, skip, 2'b00};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q   <= '0;
            opnd_q  <= '0;
            pc_q    <= '0;
            results <= '0;
            next_pc <= '0;
        end else begin
            if (accept) begin
                ctx_q  <= start_ctx;
                opnd_q <= operands;
                pc_q   <= pc_in;
            end
            if (fin) begin
                results <= res_d;
                next_pc <= npc_d;
            end
        end
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(results)); // R12
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(next_pc)); // R12
    AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctx_q) && $stable(opnd_q)); // R8
    AST_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !accept); // R8
endmodule

// File: tb/test_rfu_array.sv
module test_rfu_array;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_ctx = '0;
    logic [5:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic start = 1'b0;
    logic [1:0] start_ctx = '0;
    logic [31:0] pc_in = '0;
    logic [255:0] operands = '0;
    logic busy, done;
    logic [191:0] results;
    logic [31:0] next_pc;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rfu_array i_rfu_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctx(cfg_ctx),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .start(start),
        .start_ctx(start_ctx), .pc_in(pc_in), .operands(operands),
        .busy(busy), .done(done), .results(results), .next_pc(next_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] res(input int k);
        return results[k*32 +: 32];
    endfunction

    function automatic logic [31:0] ref_op(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            0: return a;
            1: return a + b;
            2: return a - b;
            3: return a & b;
            4: return a | b;
            5: return a ^ b;
            6: return ~(a | b);
            7: return a << b[4:0];
            8: return a >> b[4:0];
            9: return 32'($signed(a) >>> b[4:0]);
            10: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            11: return (a < b) ? 32'd1 : 32'd0;
            12: return (a == b) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] uw(input int op, input int sa, input int sb);
        return {20'd0, 4'(sb), 4'(sa), 4'(op)};
    endfunction

    function automatic logic [31:0] ctrl(input int depth, input bit bren, input int bunit, input int skp);
        return {8'd0, 8'(skp), 7'd0, 5'(bunit), bren, 3'(depth)};
    endfunction

    task automatic wr(input int ctx, input int addr, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctx = 2'(ctx); cfg_addr = 6'(addr); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_op(input int i, input logic [31:0] v);
        operands[i*32 +: 32] = v;
    endtask

    // run one instruction; returns cycles from start edge to done
    task automatic run(input int ctx, input logic [31:0] pc, output int lat);
        @(negedge clk);
        start = 1'b1; start_ctx = 2'(ctx); pc_in = pc;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        for (int k = 0; k < 6; k++) chk("R1 result", res(k), 0);
        chk("R1 next_pc", next_pc, 0);
    endtask

    // Row 1 units 0..3 use ops o0..o3 on taps 0/1 (units 0,1,3) and 2/3 (unit 2)
    task automatic t_ops(input int o0, input int o1, input int o2, input int o3,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] d);
        int lat;
        wr(0, 0, uw(o0, 4, 5));
        wr(0, 1, uw(o1, 4, 5));
        wr(0, 2, uw(o2, 6, 7));
        wr(0, 3, uw(o3, 4, 5));
        set_op(0, a); set_op(1, b); set_op(2, c); set_op(3, d);
        run(0, 32'h400, lat);
        chk("R7 latency depth1", 32'(lat), 1);
        chk("R2 unit0", res(0), ref_op(o0, a, b));
        chk("R2 unit1", res(1), ref_op(o1, a, b));
        chk("R3 unit2", res(2), ref_op(o2, c, d));
        chk("R3 unit3", res(3), ref_op(o3, a, b));
        chk("R11 out of range index", res(4), 0);
        chk("R11 result5 unit0", res(5), ref_op(o0, a, b));
    endtask

    task automatic t_setup_ctx0();
        for (int j = 0; j < 7; j++) wr(0, 20 + j, 32'(j));
        for (int k = 0; k < 4; k++) wr(0, 34 + k, 32'(k));
        wr(0, 38, 32'd20);
        wr(0, 39, 32'd0);
        wr(0, 40, ctrl(1, 1'b0, 0, 6));
        wr(0, 41, 32'h0000_1000);
    endtask

    task automatic t_nextpc();
        int lat;
        t_ops(1, 2, 7, 10, 32'd5, 32'd7, 32'd3, 32'd36);
        chk("R10 sequential pc", next_pc, 32'h418);
        wr(0, 40, ctrl(1, 1'b1, 3, 6));
        set_op(0, 32'd5); set_op(1, 32'd7);
        run(0, 32'h400, lat);
        chk("R10 branch taken", next_pc, 32'h1000);
        set_op(0, 32'd9);
        run(0, 32'h800, lat);
        chk("R10 branch not taken", next_pc, 32'h818);
        wr(0, 40, ctrl(1, 1'b0, 0, 6));
    endtask

    // depth-5 graph through both long links
    task automatic t_links();
        int lat;
        wr(1, 3, uw(0, 10, 0));     // row1 col3 = tap6
        wr(1, 7, uw(0, 4, 0));      // row2 col3 = row2 tap0 (tap7)
        wr(1, 4, uw(4, 11, 13));    // row2 col0: codes 11/13 give zero here
        wr(1, 12, uw(1, 13, 5));    // row4 col0 = linkB + row4 tap1 (tap12)
        wr(1, 16, uw(1, 11, 4));    // row5 col0 = linkA + row5 tap0 (tap13)
        wr(1, 26, 32'd6);
        wr(1, 27, 32'd7);
        wr(1, 32, 32'd4);
        wr(1, 33, 32'd5);
        wr(1, 34, 32'd16);
        wr(1, 35, 32'd12);
        wr(1, 36, 32'd4);
        wr(1, 40, ctrl(5, 1'b0, 0, 1));
        set_op(4, 32'h0000_0100); set_op(5, 32'h0000_0020);
        set_op(6, 32'h0003_0000); set_op(7, 32'h0500_0000);
        run(1, 32'h100, lat);
        chk("R7 latency depth5", 32'(lat), 5);
        chk("R5 link from row1", res(0), 32'h0003_0020);
        chk("R5 link from row2", res(1), 32'h0500_0100);
        chk("R5 link zero outside rows", res(2), 0);
        chk("R4 taps row5 row4", next_pc, 32'h104);
    endtask

    // spiral through row 3 (rightward) then row 4 (leftward)
    task automatic t_spiral();
        int lat;
        wr(2, 8,  uw(4, 4, 12));    // row3 col0: tap9 | left edge (zero)
        wr(2, 9,  uw(1, 12, 5));    // + tap10
        wr(2, 10, uw(1, 12, 12));   // doubled
        wr(2, 11, uw(0, 12, 0));    // pass
        wr(2, 15, uw(1, 3, 12));    // row4 col3: prev + right edge (zero)
        wr(2, 14, uw(1, 12, 4));    // row4 col2: right neighbour + tap11
        wr(2, 29, 32'd1);
        wr(2, 30, 32'd2);
        wr(2, 31, 32'd3);
        wr(2, 34, 32'd11);
        wr(2, 35, 32'd14);
        wr(2, 36, 32'd8);
        wr(2, 37, 32'd15);
        wr(2, 40, ctrl(4, 1'b0, 0, 0));
        set_op(1, 32'h10); set_op(2, 32'h5); set_op(3, 32'h1000);
        run(2, 32'h0, lat);
        chk("R7 latency depth4", 32'(lat), 4);
        chk("R6 row3 chain", res(0), 32'h2A);
        chk("R6 row4 reverse", res(1), 32'h102A);
        chk("R6 left edge zero", res(2), 32'h10);
        chk("R6 right edge zero", res(3), 32'h2A);
        // R12: results hold across operand changes
        set_op(1, 32'hFFFF); set_op(3, 32'h7777);
        repeat (4) @(negedge clk);
        chk("R12 hold result", res(1), 32'h102A);
        chk("R12 hold pc", next_pc, 32'h0);
    endtask

    task automatic t_clamp();
        int lat;
        wr(3, 0, uw(0, 4, 0));
        wr(3, 34, 32'd0);
        wr(3, 35, 32'd25);
        set_op(0, 32'hABCD);
        wr(3, 40, ctrl(0, 1'b0, 0, 0));
        run(3, 32'h0, lat);
        chk("R7 depth0 counts as 1", 32'(lat), 1);
        chk("R11 index 25 zero", res(1), 0);
        chk("R9 context 3", res(0), 32'hABCD);
        wr(3, 40, ctrl(7, 1'b0, 0, 0));
        run(3, 32'h0, lat);
        chk("R7 depth7 clamps to 5", 32'(lat), 5);
        wr(3, 40, ctrl(3, 1'b0, 0, 0));
        run(3, 32'h0, lat);
        chk("R7 depth3", 32'(lat), 3);
    endtask

    task automatic t_busy_ignore();
        int lat;
        set_op(4, 32'h1); set_op(5, 32'h2); set_op(6, 32'h30); set_op(7, 32'h400);
        @(negedge clk);
        start = 1'b1; start_ctx = 2'd1; pc_in = 32'h200;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy while evaluating", 32'(busy), 1);
        @(negedge clk);
        start = 1'b1; start_ctx = 2'd0; pc_in = 32'h900;
        set_op(5, 32'hF000);
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 latency unchanged", 32'(lat), 5);
        chk("R8 result from first run", res(0), 32'h32);
        chk("R8 pc from first run", next_pc, 32'h204);
        @(negedge clk);
        chk("R7 done one cycle", 32'(done), 0);
        repeat (3) @(negedge clk);
        chk("R8 no second run", 32'(busy | done), 0);
    endtask

    task automatic t_ctx_isolation();
        int lat;
        // context 0 must still hold its own graph after other contexts were written
        set_op(0, 32'd40); set_op(1, 32'd2);
        run(0, 32'h400, lat);
        chk("R9 ctx0 intact", res(0), ref_op(1, 32'd40, 32'd2));
        chk("R9 ctx0 skip", next_pc, 32'h418);
    endtask

    initial begin
        #40000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_setup_ctx0();
        t_ops(1, 2, 7, 10, 32'd5, 32'd7, 32'd3, 32'd36);
        t_ops(1, 2, 7, 10, 32'h8000_0000, 32'd1, 32'hF0, 32'h1F);
        t_ops(5, 6, 9, 11, 32'hF0F0_1234, 32'h0FF0_4321, 32'h8000_0040, 32'd33);
        t_ops(3, 4, 8, 12, 32'hAAAA_5555, 32'hAAAA_5555, 32'h8000_0040, 32'd68);
        t_ops(13, 12, 0, 11, 32'h1, 32'h2, 32'h77, 32'd0);
        t_ops(1, 2, 7, 10, 32'd40, 32'd2, 32'd3, 32'd36);
        t_nextpc();
        t_links();
        t_spiral();
        t_clamp();
        t_busy_ignore();
        t_ctx_isolation();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule